// File: doc/BRIEF.md
# Descriptor ring walker for a DMA network port

This block runs the descriptor bookkeeping of a DMA network port, with one receive channel and one transmit channel. Software builds a ring of two-word descriptors in memory. The first word holds status and control. The second word holds the buffer address. Software loads a ring start pointer for each direction and sets that direction's run flag. The engine then reads the descriptor at the current position. If software still owns the descriptor, the engine stops. If the descriptor is handed over, the engine offers the buffer to the framing logic as a job. When the framing logic reports that the frame is finished, the engine writes the status word back and moves to the next descriptor.

Status word layout: bit 11 marks the descriptor as handed to hardware. Bit 12 closes the ring. Bits 10:0 hold a byte count. Bits 16:13 hold completion flags. The descriptor after the current one sits 8 bytes further on, unless the close-ring bit is set. In that case scanning returns to the start pointer, so a ring of one descriptor uses the same descriptor again and again. Both channels share one word-wide memory port, and receive has priority on it.

Job, completion and memory transfers use valid/ready handshakes. A request or offer, once raised, stays raised with its payload unchanged until the cycle in which ready is sampled high. The consumer may hold ready low for as long as it likes. Pointer writes and run flags are plain control pins.

Top module: `ring_engine`

## Requirements
- R1: After reset, both run flags are low, no memory request is raised, and neither job output is valid.
- R2: After a start pointer write and a pulse on the run-flag set input, the first memory access of that direction reads the status word at the start pointer.
- R3: If a fetched status word has bit 11 clear, the engine clears that direction's run flag, offers no job, writes nothing, and stays stopped until the set input is pulsed again.
- R4: A job is offered only for a descriptor with bit 11 set. The job carries the second descriptor word as the buffer address and status bits 10:0 as the length.
- R5: A transmit write-back keeps the descriptor's length and bit 12, clears bit 11, and sets error bits from tx_done_err: bit 14 = retry limit (err[0]), bit 15 = underrun (err[1]), bit 16 = late collision (err[2]).
- R6: A receive write-back puts rx_done_len into bits 10:0, keeps bit 12, clears bit 11, and sets bits from rx_done_err: bit 13 = frame too long (err[0]), bit 14 = alignment (err[1]), bit 15 = overrun (err[2]), bit 16 = CRC (err[3]).
- R7: After a write-back, the next descriptor is at the current address plus 8 when bit 12 was clear, and at the start pointer when bit 12 was set.
- R8: In a ring of one descriptor with bit 12 set, every fetch goes to that same descriptor and to no neighbouring address.
- R9: A memory request holds its address, direction and write data until mem_ready is high. Read data is taken from mem_rdata in the cycle after the read is accepted.
- R10: When both directions request the memory and no stalled request is being held, the receive request is served first.
- R11: A job offer holds its address and length until it is accepted. Completion ready is high only while an accepted job is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_base_wr | input | 1 | Load receive start pointer |
| rx_base | input | ADDR_W | Receive start pointer (byte address, 8-byte aligned) |
| rx_en_set | input | 1 | Pulse to set the receive run flag |
| rx_en | output | 1 | Receive run flag |
| tx_base_wr | input | 1 | Load transmit start pointer |
| tx_base | input | ADDR_W | Transmit start pointer (byte address, 8-byte aligned) |
| tx_en_set | input | 1 | Pulse to set the transmit run flag |
| tx_en | output | 1 | Transmit run flag |
| mem_req | output | 1 | Descriptor memory request valid |
| mem_ready | input | 1 | Descriptor memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after acceptance |
| tx_job_valid | output | 1 | Transmit buffer offered |
| tx_job_ready | input | 1 | Framing logic takes the transmit job |
| tx_job_addr | output | ADDR_W | Transmit buffer address |
| tx_job_len | output | 11 | Transmit frame length |
| tx_done_valid | input | 1 | Transmit frame finished |
| tx_done_ready | output | 1 | Engine accepts transmit completion |
| tx_done_err | input | 3 | Transmit error flags |
| rx_job_valid | output | 1 | Receive buffer offered |
| rx_job_ready | input | 1 | Framing logic takes the receive buffer |
| rx_job_addr | output | ADDR_W | Receive buffer address |
| rx_job_len | output | 11 | Length field of the receive descriptor |
| rx_done_valid | input | 1 | Received frame finished |
| rx_done_ready | output | 1 | Engine accepts receive completion |
| rx_done_len | input | 11 | Received frame length |
| rx_done_err | input | 4 | Receive error flags |

## Verification
The properties assume that start pointers are 8-byte aligned. They also assume that a start pointer is written only while its run flag is low, and that completions arrive only after their job was accepted. The stimulus writes pointers before pulsing the set inputs. It offers a completion only after taking the job, and it changes descriptor memory only while the engine is stopped or cannot touch that word. The memory model sometimes stalls mem_ready every other cycle, so the hold rules are exercised under back-pressure.

// File: rtl/ring_pkg.sv
package ring_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int DESC_BYTES = 8;
  localparam int OWN_BIT    = 11;
  localparam int CLOSE_BIT  = 12;
  localparam int CNT_W      = 11;
  localparam int FLAG_LSB   = 13;
  localparam int FLAG_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_STAT, ST_WT_STAT, ST_RD_BUF,
    ST_WT_BUF, ST_OFFER, ST_BUSY, ST_WB
  } walk_state_t;
endpackage

// File: rtl/ring_arb.sv
module ring_arb #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_req,
  input  logic              rx_we,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              tx_req,
  input  logic              tx_we,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rx_gnt,
  output logic              tx_gnt
);
  timeunit 1ns; timeprecision 1ps;

  logic hold_q, hold_rx_q, pick_rx;

  // a stalled request keeps the port until it is accepted
  assign pick_rx   = hold_q ? hold_rx_q : rx_req;
  assign mem_req   = rx_req | tx_req;
  assign mem_we    = pick_rx ? rx_we    : tx_we;
  assign mem_addr  = pick_rx ? rx_addr  : tx_addr;
  assign mem_wdata = pick_rx ? rx_wdata : tx_wdata;
  assign rx_gnt    = mem_ready & rx_req & pick_rx;
  assign tx_gnt    = mem_ready & tx_req & ~pick_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_rx_q <= 1'b0;
    end else begin
      hold_q    <= mem_req & ~mem_ready;
      hold_rx_q <= pick_rx;
    end
  end
endmodule

// File: rtl/ring_chan.sv
module ring_chan
  import ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter bit IS_RX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              run_set,
  output logic              run,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic              gnt,
  input  logic [DATA_W-1:0] rdata,
  output logic              job_valid,
  input  logic              job_ready,
  output logic [ADDR_W-1:0] job_addr,
  output logic [CNT_W-1:0]  job_len,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic [CNT_W-1:0]  done_len,
  input  logic [FLAG_W-1:0] done_err
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(DESC_BYTES / 2);

  walk_state_t        state;
  logic [ADDR_W-1:0]  base_q, cur_q, buf_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               close_q;
  logic [FLAG_W-1:0]  flag_q;

  assign req        = (state == ST_RD_STAT) | (state == ST_RD_BUF) | (state == ST_WB);
  assign we         = (state == ST_WB);
  assign addr       = (state == ST_RD_BUF) ? cur_q + WORD : cur_q;
  assign job_valid  = (state == ST_OFFER);
  assign job_addr   = buf_q;
  assign job_len    = cnt_q;
  assign done_ready = (state == ST_BUSY);

  always_comb begin
    wdata                         = '0;
    wdata[CNT_W-1:0]              = cnt_q;
    wdata[CLOSE_BIT]              = close_q;
    wdata[FLAG_LSB +: FLAG_W]     = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      run     <= 1'b0;
      base_q  <= '0;
      cur_q   <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      close_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      case (state)
        ST_IDLE:    if (run) state <= ST_RD_STAT;
        ST_RD_STAT: if (gnt) state <= ST_WT_STAT;
        ST_WT_STAT: begin
          if (rdata[OWN_BIT]) begin
            cnt_q   <= rdata[CNT_W-1:0];
            close_q <= rdata[CLOSE_BIT];
            state   <= ST_RD_BUF;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_RD_BUF:  if (gnt) state <= ST_WT_BUF;
        ST_WT_BUF: begin
          buf_q <= rdata[ADDR_W-1:0];
          state <= ST_OFFER;
        end
        ST_OFFER:   if (job_ready) state <= ST_BUSY;
        ST_BUSY: begin
          if (done_valid) begin
            flag_q <= done_err;
            if (IS_RX) cnt_q <= done_len;
            state <= ST_WB;
          end
        end
        ST_WB: begin
          if (gnt) begin
            cur_q <= close_q ? base_q : cur_q + STEP;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (state == ST_WT_STAT && !rdata[OWN_BIT]) run <= 1'b0;
      if (run_set) run <= 1'b1;
      if (base_wr) begin
        base_q <= base_in;
        cur_q  <= base_in;
      end
    end
  end
endmodule

// File: rtl/ring_engine.sv
module ring_engine
  import ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_base_wr,
  input  logic [ADDR_W-1:0] rx_base,
  input  logic              rx_en_set,
  output logic              rx_en,
  input  logic              tx_base_wr,
  input  logic [ADDR_W-1:0] tx_base,
  input  logic              tx_en_set,
  output logic              tx_en,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_job_valid,
  input  logic              tx_job_ready,
  output logic [ADDR_W-1:0] tx_job_addr,
  output logic [10:0]       tx_job_len,
  input  logic              tx_done_valid,
  output logic              tx_done_ready,
  input  logic [2:0]        tx_done_err,
  output logic              rx_job_valid,
  input  logic              rx_job_ready,
  output logic [ADDR_W-1:0] rx_job_addr,
  output logic [10:0]       rx_job_len,
  input  logic              rx_done_valid,
  output logic              rx_done_ready,
  input  logic [10:0]       rx_done_len,
  input  logic [3:0]        rx_done_err
);
  timeunit 1ns; timeprecision 1ps;

  logic              rx_req, rx_we, rx_gnt;
  logic              tx_req, tx_we, tx_gnt;
  logic [ADDR_W-1:0] rx_addr, tx_addr;
  logic [DATA_W-1:0] rx_wdata, tx_wdata;

  ring_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .base_wr(rx_base_wr), .base_in(rx_base), .run_set(rx_en_set), .run(rx_en),
    .req(rx_req), .we(rx_we), .addr(rx_addr), .wdata(rx_wdata),
    .gnt(rx_gnt), .rdata(mem_rdata),
    .job_valid(rx_job_valid), .job_ready(rx_job_ready),
    .job_addr(rx_job_addr), .job_len(rx_job_len),
    .done_valid(rx_done_valid), .done_ready(rx_done_ready),
    .done_len(rx_done_len), .done_err(rx_done_err)
  );

  // transmit flags sit one position up: retry limit lands on bit 14
  ring_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .base_wr(tx_base_wr), .base_in(tx_base), .run_set(tx_en_set), .run(tx_en),
    .req(tx_req), .we(tx_we), .addr(tx_addr), .wdata(tx_wdata),
    .gnt(tx_gnt), .rdata(mem_rdata),
    .job_valid(tx_job_valid), .job_ready(tx_job_ready),
    .job_addr(tx_job_addr), .job_len(tx_job_len),
    .done_valid(tx_done_valid), .done_ready(tx_done_ready),
    .done_len('0), .done_err({tx_done_err, 1'b0})
  );

  ring_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rx_req(rx_req), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .tx_req(tx_req), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .mem_ready(mem_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt)
  );
endmodule

// File: rtl/ring_engine_chk.sv
module ring_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rx_en,
  input logic              tx_en,
  input logic              rx_job_valid,
  input logic              rx_job_ready,
  input logic [ADDR_W-1:0] rx_job_addr,
  input logic [10:0]       rx_job_len,
  input logic              tx_job_valid,
  input logic              tx_job_ready,
  input logic [ADDR_W-1:0] tx_job_addr,
  input logic [10:0]       tx_job_len,
  input logic              rx_req,
  input logic              tx_req,
  input logic              tx_gnt
);
  timeunit 1ns; timeprecision 1ps;

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_wb_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[11]);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_rx_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req && tx_req && !$past(mem_req && !mem_ready) |-> !tx_gnt);

  assert_tx_offer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_job_valid && !tx_job_ready |=> tx_job_valid && $stable(tx_job_addr) && $stable(tx_job_len));

  assert_rx_offer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_job_valid && !rx_job_ready |=> rx_job_valid && $stable(rx_job_addr) && $stable(rx_job_len));

  assert_tx_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_job_valid);

  assert_rx_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_job_valid);
endmodule

bind ring_engine ring_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rx_en(rx_en), .tx_en(tx_en),
  .rx_job_valid(rx_job_valid), .rx_job_ready(rx_job_ready),
  .rx_job_addr(rx_job_addr), .rx_job_len(rx_job_len),
  .tx_job_valid(tx_job_valid), .tx_job_ready(tx_job_ready),
  .tx_job_addr(tx_job_addr), .tx_job_len(tx_job_len),
  .rx_req(rx_req), .tx_req(tx_req), .tx_gnt(tx_gnt)
);

// File: tb/tb_ring_engine.sv
module tb_ring_engine;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [31:0] OWN   = 32'h1 << 11;
  localparam logic [31:0] CLOSE = 32'h1 << 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_base_wr = 0, tx_base_wr = 0, rx_en_set = 0, tx_en_set = 0;
  logic [31:0] rx_base = 0, tx_base = 0;
  logic        rx_en, tx_en;
  logic        mem_req, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_job_valid, tx_job_ready = 0, tx_done_valid = 0, tx_done_ready;
  logic [31:0] tx_job_addr;
  logic [10:0] tx_job_len;
  logic [2:0]  tx_done_err = 0;
  logic        rx_job_valid, rx_job_ready = 0, rx_done_valid = 0, rx_done_ready;
  logic [31:0] rx_job_addr;
  logic [10:0] rx_job_len, rx_done_len = 0;
  logic [3:0]  rx_done_err = 0;

  int n_chk = 0, n_bad = 0;
  bit stall = 0;
  logic [7:0] cyc = 0;

  logic [31:0] mem [0:63];
  int          rd_cnt [0:63];
  bit          touched [0:63];
  int          wr_cnt = 0;
  bit          first_seen = 0;
  logic [31:0] first_addr = 0;
  logic [31:0] rdata_q = 0;

  always #2.5 clk = ~clk;

  ring_engine dut (.*);

  assign mem_ready = !stall || cyc[0];
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      touched[mem_addr[7:2]] = 1;
      if (!first_seen) begin first_seen = 1; first_addr = mem_addr; end
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt++;
      end else begin
        rdata_q <= mem[mem_addr[7:2]];
        rd_cnt[mem_addr[7:2]]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 64; i++) begin rd_cnt[i] = 0; touched[i] = 0; end
    first_seen = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_tx(input logic [31:0] b);
    tx_base = b; tx_base_wr = 1; @(negedge clk); tx_base_wr = 0;
    tx_en_set = 1; @(negedge clk); tx_en_set = 0;
  endtask

  task automatic start_rx(input logic [31:0] b);
    rx_base = b; rx_base_wr = 1; @(negedge clk); rx_base_wr = 0;
    rx_en_set = 1; @(negedge clk); rx_en_set = 0;
  endtask

  task automatic serve_tx(input logic [31:0] exp_addr, input logic [10:0] exp_len, input logic [2:0] err);
    int n = 0;
    while (!tx_job_valid && n < 300) begin @(negedge clk); n++; end
    check(tx_job_valid, "R4 tx offer", {31'b0, tx_job_valid}, 1);
    check(tx_job_addr == exp_addr, "R4 tx addr", tx_job_addr, exp_addr);
    check(tx_job_len == exp_len, "R4 tx len", {21'b0, tx_job_len}, {21'b0, exp_len});
    check(!tx_done_ready, "R11 tx done before job", {31'b0, tx_done_ready}, 0);
    tx_job_ready = 1; @(negedge clk); tx_job_ready = 0;
    tx_done_err = err; tx_done_valid = 1;
    n = 0;
    while (!tx_done_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk); tx_done_valid = 0;
  endtask

  task automatic serve_rx(input logic [31:0] exp_addr, input logic [10:0] flen, input logic [3:0] err);
    int n = 0;
    while (!rx_job_valid && n < 300) begin @(negedge clk); n++; end
    check(rx_job_valid, "R4 rx offer", {31'b0, rx_job_valid}, 1);
    check(rx_job_addr == exp_addr, "R4 rx addr", rx_job_addr, exp_addr);
    check(!rx_done_ready, "R11 rx done before job", {31'b0, rx_done_ready}, 0);
    rx_job_ready = 1; @(negedge clk); rx_job_ready = 0;
    rx_done_len = flen; rx_done_err = err; rx_done_valid = 1;
    n = 0;
    while (!rx_done_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk); rx_done_valid = 0;
  endtask

  task automatic t_reset();
    check(!rx_en && !tx_en, "R1 run flags", {30'b0, rx_en, tx_en}, 0);
    check(!mem_req, "R1 mem_req", {31'b0, mem_req}, 0);
    check(!rx_job_valid && !tx_job_valid, "R1 job valid", {30'b0, rx_job_valid, tx_job_valid}, 0);
  endtask

  task automatic t_empty_stop();
    int w0;
    mem[8] = 32'h0000_0040;
    clear_log(); w0 = wr_cnt;
    start_rx(32'h20);
    idle(20);
    check(first_addr == 32'h20, "R2 first fetch", first_addr, 32'h20);
    check(!rx_en, "R3 run cleared", {31'b0, rx_en}, 0);
    check(!rx_job_valid, "R3 no job", {31'b0, rx_job_valid}, 0);
    check(wr_cnt == w0, "R3 no write", wr_cnt, w0);
    check(rd_cnt[8] == 1, "R3 stays stopped", rd_cnt[8], 1);
  endtask

  task automatic t_tx_ring();
    mem[32] = OWN | 32'd60;          mem[33] = 32'h1234;
    mem[34] = OWN | CLOSE | 32'd100; mem[35] = 32'h2000;
    clear_log();
    start_tx(32'h80);
    serve_tx(32'h1234, 11'd60, 3'b000);
    idle(40);
    check(mem[32] == 32'd60, "R5 clean write-back", mem[32], 32'd60);
    serve_tx(32'h2000, 11'd100, 3'b101);
    idle(40);
    check(mem[34] == (CLOSE | 32'd100 | (32'h1 << 14) | (32'h1 << 16)), "R5 flags",
          mem[34], CLOSE | 32'd100 | (32'h1 << 14) | (32'h1 << 16));
    check(rd_cnt[32] == 2, "R7 close returns to base", rd_cnt[32], 2);
    check(!touched[36], "R7 no step past close", {31'b0, touched[36]}, 0);
    check(!tx_en, "R3 tx stop on released", {31'b0, tx_en}, 0);
  endtask

  task automatic t_rx_ring_stalled();
    int n = 0;
    stall = 1;
    mem[0] = OWN | 32'd1500;         mem[1] = 32'h3000;
    mem[2] = OWN;                    mem[3] = 32'h3800;
    mem[4] = OWN | CLOSE;            mem[5] = 32'h4000;
    clear_log();
    start_rx(32'h0);
    while (!rx_job_valid && n < 300) begin @(negedge clk); n++; end
    check(rx_job_len == 11'd1500, "R4 rx len field", {21'b0, rx_job_len}, 1500);
    serve_rx(32'h3000, 11'd64, 4'b0000);
    idle(40);
    check(mem[0] == 32'd64, "R6 length", mem[0], 64);
    serve_rx(32'h3800, 11'd1519, 4'b1001);
    idle(40);
    check(mem[2] == (32'd1519 | (32'h1 << 13) | (32'h1 << 16)), "R6 toolong+crc",
          mem[2], 32'd1519 | (32'h1 << 13) | (32'h1 << 16));
    serve_rx(32'h4000, 11'd200, 4'b0110);
    idle(40);
    check(mem[4] == (CLOSE | 32'd200 | (32'h1 << 14) | (32'h1 << 15)), "R6 align+overrun R9",
          mem[4], CLOSE | 32'd200 | (32'h1 << 14) | (32'h1 << 15));
    check(rd_cnt[0] == 2 && !touched[6], "R7 rx wrap", rd_cnt[0], 2);
    check(!rx_en, "R3 rx stop", {31'b0, rx_en}, 0);
    stall = 0;
  endtask

  task automatic t_single_entry();
    mem[48] = OWN | CLOSE | 32'd5; mem[49] = 32'h5000;
    clear_log();
    start_tx(32'hC0);
    serve_tx(32'h5000, 11'd5, 3'b010);
    idle(40);
    check(mem[48] == (CLOSE | 32'd5 | (32'h1 << 15)), "R8 write-back",
          mem[48], CLOSE | 32'd5 | (32'h1 << 15));
    check(rd_cnt[48] == 2, "R8 refetch same", rd_cnt[48], 2);
    check(!touched[50], "R8 no neighbour", {31'b0, touched[50]}, 0);
    mem[48] = OWN | CLOSE | 32'd7;
    tx_en_set = 1; @(negedge clk); tx_en_set = 0;
    serve_tx(32'h5000, 11'd7, 3'b000);
    idle(40);
    check(mem[48] == (CLOSE | 32'd7), "R8 rearmed", mem[48], CLOSE | 32'd7);
  endtask

  task automatic t_priority();
    mem[16] = OWN | CLOSE; mem[17] = 32'h6000;
    mem[36] = OWN | CLOSE | 32'd10; mem[37] = 32'h7000;
    rx_base = 32'h40; tx_base = 32'h90; rx_base_wr = 1; tx_base_wr = 1;
    @(negedge clk); rx_base_wr = 0; tx_base_wr = 0;
    clear_log();
    rx_en_set = 1; tx_en_set = 1; @(negedge clk); rx_en_set = 0; tx_en_set = 0;
    idle(4);
    check(first_addr == 32'h40, "R10 rx served first", first_addr, 32'h40);
    serve_rx(32'h6000, 11'd33, 4'b0000);
    serve_tx(32'h7000, 11'd10, 3'b000);
    idle(40);
    check(mem[16] == (CLOSE | 32'd33) && mem[36] == (CLOSE | 32'd10), "R10 both done", mem[16], CLOSE | 32'd33);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty_stop();
    t_tx_ring();
    t_rx_ring_stalled();
    t_single_entry();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule